// File: doc/BRIEF.md
# ADC Output Data Formatter

This block sits between the digital correction stage of a pipelined converter and the parallel output pins. Each conversion result arrives as an offset-binary word with an overrange flag. The block delays the word and the flag together through a fixed pipeline. It then recodes the word into offset binary, twos complement or Gray code, and can complement every data bit. The result goes onto a parallel bus, together with a data clock that runs at the sample rate.

The block runs on a clock at twice the sample rate. An internal phase bit splits each sample period into two halves. A new sample is taken at every edge where the phase bit is low; these are the capture edges. In single data rate mode the whole word stays on the bus for both halves. In double data rate mode the word is cut in two. The low bits go out in the half where the data clock is high at normal polarity, and the high bits go out in the other half. The lane-layout and clock-polarity settings are latched only at capture edges, so one word is never split across two modes.

Top module: `adcOutFormatter`

## Requirements
- R1: While rstN is low, busData, busOvr and dataClk are all 0.
- R2: With the polarity bit at 0, dataClk toggles on every clk edge after reset. It is 1 in the clk cycle that follows each capture edge. The first edge after reset is a capture edge, and capture edges then alternate with other edges.
- R3: Let a sample be presented at capture edge k. Its formatted word and flag are loaded at capture edge k+LATENCY-1, and in single data rate mode they stay on busData and busOvr for both following clk cycles. LATENCY defaults to 7.
- R4: codeSel = 00 gives offset binary: busData equals the raw word. This is the reset default.
- R5: codeSel = 01 gives twos complement: the raw word with bit 10 inverted. So 000_0000_0000 becomes 100_0000_0000, and 111_1111_1111 becomes 011_1111_1111.
- R6: codeSel = 10 gives Gray code, g = b ^ (b >> 1), where b is the raw word. codeSel = 11 behaves like offset binary.
- R7: With invertEn = 1, all 11 data bits are complemented after code conversion.
- R8: busOvr carries the overrange flag of the same sample as the word on busData. It has the same latency and changes only on capture edges.
- R9: In double data rate mode, the half where dataClk is high at normal polarity carries bits 4..0 on lanes 4..0, with lanes 10..5 at 0. The other half carries bits 10..5 on lanes 5..0, with lanes 10..6 at 0.
- R10: clkInvert = 1 inverts dataClk relative to R2.
- R11: A change to ddrEn or clkInvert between capture edges does not affect the word already on the bus. The new setting takes effect at the next capture edge. codeSel and invertEn are sampled at the capture edge that loads the word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at twice the sample rate |
| rstN | input | 1 | Asynchronous active-low reset |
| sampleIn | input | 11 | Raw conversion result, offset binary |
| overIn | input | 1 | Overrange flag of sampleIn |
| codeSel | input | 2 | Output code: 00 offset, 01 twos complement, 10 Gray, 11 offset |
| invertEn | input | 1 | Complement all data bits |
| ddrEn | input | 1 | 1 selects split-word double data rate lanes |
| clkInvert | input | 1 | Invert the data clock |
| busData | output | 11 | Output lanes |
| busOvr | output | 1 | Overrange flag aligned to busData |
| dataClk | output | 1 | Data clock at the sample rate |

## Verification
A wrong phase bit shows up at once on dataClk, which stops alternating or alternates out of step with the capture edges. A pipeline stage that drops or repeats a word shows up LATENCY sample periods later: busData and busOvr become offset by one sample against the stream that was fed in. If the lane setting is latched in the middle of a word, the second half-cycle of that word shows the wrong layout. In double data rate mode, a lane mux fault shows up in every half-cycle, either as nonzero idle lanes or as half-words that are swapped or shifted.

// File: rtl/adcFmtPkg.sv
package adcFmtPkg;

  typedef enum logic [1:0] {
    CODE_OFFSET = 2'b00,
    CODE_TWOS   = 2'b01,
    CODE_GRAY   = 2'b10,
    CODE_SPARE  = 2'b11
  } codeSel_e;

  // Lane settings that must only change on a word boundary
  typedef struct packed {
    logic ddr;
    logic clkInv;
  } laneCfg_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic wordTick;  // this edge is a capture edge
    logic lowHalf;   // current cycle is the first half of a word
  } fmtStrobe_t;

endpackage

// File: rtl/adcFmtCtrl.sv
module adcFmtCtrl
  import adcFmtPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  laneCfg_t   cfgIn,
  output laneCfg_t   cfgQ,
  output fmtStrobe_t strobe,
  output logic       dataClk
);

  logic phaseQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phaseQ <= 1'b0;
    end else begin
      phaseQ <= ~phaseQ;
    end
  end

  // Lane settings are taken only at capture edges
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgQ <= '0;
    end else if (!phaseQ) begin
      cfgQ <= cfgIn;
    end
  end

  always_comb begin
    strobe.wordTick = ~phaseQ;
    strobe.lowHalf  = phaseQ;
  end

  assign dataClk = phaseQ ^ cfgQ.clkInv;

endmodule

// File: rtl/adcFmtDatapath.sv
module adcFmtDatapath
  import adcFmtPkg::*;
#(
  parameter int WIDTH   = 11,
  parameter int LATENCY = 7
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] sampleIn,
  input  logic             overIn,
  input  fmtStrobe_t       strobe,
  input  logic [1:0]       codeSel,
  input  logic             invertEn,
  input  logic             laneDdr,
  output logic [WIDTH-1:0] busData,
  output logic             busOvr
);

  localparam int STAGES = LATENCY - 1;
  localparam int LOW_W  = WIDTH / 2;
  localparam logic [WIDTH-1:0] SIGN_BIT = {1'b1, {(WIDTH-1){1'b0}}};

  logic [STAGES-1:0][WIDTH-1:0] pipeData;
  logic [STAGES-1:0]            pipeOvr;
  logic [WIDTH-1:0]             wordQ;
  logic                         ovrQ;
  logic [WIDTH-1:0]             coded;

  for (genvar s = 0; s < STAGES; s++) begin : gStage
    if (s == 0) begin : gHead
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          pipeData[s] <= '0;
          pipeOvr[s]  <= 1'b0;
        end else if (strobe.wordTick) begin
          pipeData[s] <= sampleIn;
          pipeOvr[s]  <= overIn;
        end
      end
    end else begin : gBody
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          pipeData[s] <= '0;
          pipeOvr[s]  <= 1'b0;
        end else if (strobe.wordTick) begin
          pipeData[s] <= pipeData[s-1];
          pipeOvr[s]  <= pipeOvr[s-1];
        end
      end
    end
  end

  function automatic logic [WIDTH-1:0] encode(input logic [WIDTH-1:0] raw,
                                              input logic [1:0] sel);
    case (codeSel_e'(sel))
      CODE_TWOS: encode = raw ^ SIGN_BIT;
      CODE_GRAY: encode = raw ^ (raw >> 1);
      default:   encode = raw;
    endcase
  endfunction

  always_comb begin
    coded = encode(pipeData[STAGES-1], codeSel);
    if (invertEn) coded = ~coded;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wordQ <= '0;
      ovrQ  <= 1'b0;
    end else if (strobe.wordTick) begin
      wordQ <= coded;
      ovrQ  <= pipeOvr[STAGES-1];
    end
  end

  always_comb begin
    busData = '0;
    if (!laneDdr) begin
      busData = wordQ;
    end else if (strobe.lowHalf) begin
      busData[LOW_W-1:0] = wordQ[LOW_W-1:0];
    end else begin
      busData[WIDTH-LOW_W-1:0] = wordQ[WIDTH-1:LOW_W];
    end
  end

  assign busOvr = ovrQ;

endmodule

// File: rtl/adcOutFormatter.sv
module adcOutFormatter
  import adcFmtPkg::*;
#(
  parameter int WIDTH   = 11,
  parameter int LATENCY = 7
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] sampleIn,
  input  logic             overIn,
  input  logic [1:0]       codeSel,
  input  logic             invertEn,
  input  logic             ddrEn,
  input  logic             clkInvert,
  output logic [WIDTH-1:0] busData,
  output logic             busOvr,
  output logic             dataClk
);

  laneCfg_t   cfgLive;
  laneCfg_t   cfgQ;
  fmtStrobe_t strobe;

  always_comb begin
    cfgLive.ddr    = ddrEn;
    cfgLive.clkInv = clkInvert;
  end

  adcFmtCtrl i_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .cfgIn   (cfgLive),
    .cfgQ    (cfgQ),
    .strobe  (strobe),
    .dataClk (dataClk)
  );

  adcFmtDatapath #(.WIDTH(WIDTH), .LATENCY(LATENCY)) i_datapath (
    .clk      (clk),
    .rstN     (rstN),
    .sampleIn (sampleIn),
    .overIn   (overIn),
    .strobe   (strobe),
    .codeSel  (codeSel),
    .invertEn (invertEn),
    .laneDdr  (cfgQ.ddr),
    .busData  (busData),
    .busOvr   (busOvr)
  );

endmodule

// File: rtl/adcFmtChecker.sv
module adcFmtChecker
  import adcFmtPkg::*;
#(
  parameter int WIDTH = 11
) (
  input logic             clk,
  input logic             rstN,
  input logic [WIDTH-1:0] busData,
  input logic             busOvr,
  input logic             dataClk,
  input fmtStrobe_t       strobe,
  input laneCfg_t         cfgQ
);

  localparam int LOW_W  = WIDTH / 2;
  localparam int HIGH_W = WIDTH - LOW_W;

  always @(negedge clk) begin
    if (!rstN) begin
      assert_reset_quiet_R1: assert (busData == '0 && !busOvr && !dataClk);
    end
  end

  assert_clk_toggles_R2: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (cfgQ.clkInv != $past(cfgQ.clkInv)) || (dataClk != $past(dataClk)));

  assert_sdr_word_held_R3: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.wordTick && !cfgQ.ddr) |=> $stable(busData));

  assert_ovr_on_boundary_R8: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.wordTick |=> $stable(busOvr));

  assert_idle_lanes_zero_R9: assert property (@(posedge clk) disable iff (!rstN)
    cfgQ.ddr |-> ((busData >> (strobe.lowHalf ? LOW_W : HIGH_W)) == '0));

  assert_cfg_word_aligned_R11: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.wordTick |=> $stable(cfgQ));

endmodule

bind adcOutFormatter adcFmtChecker #(.WIDTH(WIDTH)) u_adcFmtChecker (
  .clk     (clk),
  .rstN    (rstN),
  .busData (busData),
  .busOvr  (busOvr),
  .dataClk (dataClk),
  .strobe  (strobe),
  .cfgQ    (cfgQ)
);

// File: tb/test_adcOutFormatter.sv
module test_adcOutFormatter;

  localparam int LAT = 7;

  typedef struct {
    logic [10:0] raw;
    logic        ovr;
  } item_t;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [10:0] sampleIn = '0;
  logic        overIn = 1'b0;
  logic [1:0]  codeSel = 2'b00;
  logic        invertEn = 1'b0;
  logic        ddrEn = 1'b0;
  logic        clkInvert = 1'b0;
  logic [10:0] busData;
  logic        busOvr;
  logic        dataClk;

  int  checks = 0;
  int  fails = 0;
  bit  started = 1'b0;
  bit  midChg = 1'b0;
  bit  reported = 1'b0;
  item_t scoreQ[$];

  always #10 clk = ~clk;

  adcOutFormatter i_adcOutFormatter (
    .clk(clk), .rstN(rstN), .sampleIn(sampleIn), .overIn(overIn),
    .codeSel(codeSel), .invertEn(invertEn), .ddrEn(ddrEn), .clkInvert(clkInvert),
    .busData(busData), .busOvr(busOvr), .dataClk(dataClk)
  );

  task automatic chk(input bit ok, input string tag, input logic [10:0] act,
                     input logic [10:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic report();
    if (!reported) begin
      reported = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  function automatic logic [10:0] expWord(input logic [10:0] raw, input logic [1:0] sel,
                                          input logic inv);
    logic [10:0] w;
    case (sel)
      2'b01:   w = {~raw[10], raw[9:0]};
      2'b10:   w = raw ^ {1'b0, raw[10:1]};
      default: w = raw;
    endcase
    return inv ? ~w : w;
  endfunction

  // Driver: called at the negedge before a capture edge; returns one sample later
  task automatic send(input logic [10:0] raw, input logic ovr);
    item_t it;
    sampleIn = raw;
    overIn = ovr;
    it.raw = raw;
    it.ovr = ovr;
    scoreQ.push_back(it);
    @(negedge clk);
    @(negedge clk);
  endtask

  // Driver variant that flips lane settings between capture edges (R11)
  task automatic sendMid(input logic [10:0] raw, input logic ovr);
    item_t it;
    sampleIn = raw;
    overIn = ovr;
    it.raw = raw;
    it.ovr = ovr;
    scoreQ.push_back(it);
    @(negedge clk);
    ddrEn = ~ddrEn;
    clkInvert = ~clkInvert;
    midChg = 1'b1;
    @(negedge clk);
  endtask

  // Monitor
  initial begin
    item_t cur;
    bit have = 1'b0;
    logic [1:0] aCode = '0;
    logic aInv = 1'b0, aDdr = 1'b0, aPol = 1'b0;
    int e = 0;
    wait (started);
    forever begin
      @(posedge clk);
      #5;
      if (e >= 2 * (LAT - 1)) begin
        logic [10:0] w, expBus;
        string tag;
        bit even;
        even = (e % 2) == 0;
        if (even) begin
          midChg = 1'b0;
          if (scoreQ.size() > 0) begin
            cur = scoreQ.pop_front();
            have = 1'b1;
          end else begin
            have = 1'b0;
          end
          aCode = codeSel; aInv = invertEn; aDdr = ddrEn; aPol = clkInvert;
        end
        if (have) begin
          w = expWord(cur.raw, aCode, aInv);
          if (!aDdr) expBus = w;
          else if (even) expBus = {6'b0, w[4:0]};
          else expBus = {5'b0, w[10:5]};
          if (aDdr) tag = "R9";
          else if (aInv) tag = "R3 R7";
          else if (aCode == 2'b01) tag = "R3 R5";
          else if (aCode[1]) tag = "R3 R6";
          else tag = "R3 R4";
          if (midChg) tag = "R11";
          chk(busData == expBus, tag, busData, expBus);
          chk(busOvr == cur.ovr, midChg ? "R11" : "R8", {10'b0, busOvr}, {10'b0, cur.ovr});
          chk(dataClk == (even ^ aPol), midChg ? "R11" : (aPol ? "R10" : "R2"),
              {10'b0, dataClk}, {10'b0, even ^ aPol});
        end
      end
      e++;
    end
  end

  // Watchdog
  initial begin
    #4_000_000;
    checks++;
    fails++;
    $display("FAIL watchdog expired");
    report();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(busData == '0, "R1", busData, '0);
    chk(busOvr == 1'b0, "R1", {10'b0, busOvr}, '0);
    chk(dataClk == 1'b0, "R1", {10'b0, dataClk}, '0);
    rstN = 1'b1;
    started = 1'b1;

    // Offset binary, reset default code (R4), latency and overrange (R3, R8)
    send(11'h000, 1'b1);
    send(11'h7FF, 1'b1);
    send(11'h400, 1'b0);
    send(11'h123, 1'b0);
    send(11'h5A5, 1'b1);
    send(11'h7FF, 1'b0);
    // Twos complement with both extremes (R5)
    codeSel = 2'b01;
    send(11'h000, 1'b1);
    send(11'h7FF, 1'b1);
    send(11'h400, 1'b0);
    send(11'h3FF, 1'b0);
    // Gray and the spare code (R6)
    codeSel = 2'b10;
    send(11'h2B6, 1'b0);
    send(11'h7FF, 1'b0);
    send(11'h401, 1'b1);
    codeSel = 2'b11;
    send(11'h19C, 1'b0);
    send(11'h6E1, 1'b1);
    // Inversion after conversion (R7)
    codeSel = 2'b01;
    invertEn = 1'b1;
    send(11'h000, 1'b1);
    send(11'h0F0, 1'b0);
    codeSel = 2'b10;
    send(11'h555, 1'b0);
    invertEn = 1'b0;
    codeSel = 2'b00;
    // Double data rate lanes (R9)
    ddrEn = 1'b1;
    send(11'h7FF, 1'b1);
    send(11'h01F, 1'b0);
    send(11'h7E0, 1'b0);
    send(11'h2AA, 1'b1);
    codeSel = 2'b01;
    send(11'h155, 1'b0);
    // Clock polarity, both lane modes (R10)
    clkInvert = 1'b1;
    codeSel = 2'b00;
    send(11'h3C3, 1'b0);
    send(11'h0A5, 1'b1);
    ddrEn = 1'b0;
    send(11'h6B2, 1'b0);
    send(11'h111, 1'b1);
    // Settings flipped between capture edges (R11)
    sendMid(11'h5F0, 1'b0);
    sendMid(11'h0E7, 1'b1);
    sendMid(11'h7A1, 1'b0);
    sendMid(11'h301, 1'b1);
    // Drain
    for (int i = 0; i < LAT + 1; i++) send(11'h000, 1'b0);
    repeat (4) @(negedge clk);
    report();
  end

endmodule